// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a synthesizable behavioural model of a single-ported synchronous SRAM with one shared data bus. Every access (read, write or deselect) is presented as a command on one rising clock edge. The data belonging to that command uses the bus in the cycle that ends on the second edge after the command. A read drives its word in that cycle. A write has its data sampled from the bus at the end of that cycle. Because reads and writes use the bus in the same position of the pipeline, the two can follow each other on consecutive edges with no idle cycles between them.

The bidirectional bus is split into an input word, an output word and an output-drive enable, so that a pad ring or a bench can join them. Three chip enables, two active low and one active high, must all be active for a command to reach the array. A load/advance input does one of two things. When low, it starts a new access from the address pins. When high, it continues the previous access type at the next address in a four-word linear burst. Byte write selects pick which bytes of a word a write may change. The output enable only gates the drivers. It never stops the pipeline.

The block has no back-pressure. Every clock edge accepts exactly one command, and every data slot is used, on the following edge, in the way its command says.

Top module: `lw_sram`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `dq_oe` is low.
- R2: A read taken on edge N drives the stored word on `dq_out` with `dq_oe` high between edges N+1 and N+2, provided `oe_n` is low in that interval.
- R3: A write taken on edge N stores the word present on `dq_in` at edge N+2 at the address given at edge N.
- R4: A write changes only the bytes whose `byte_we_n` bit was low at its command edge, where bit i covers data bits 8i+7 down to 8i. All other bytes keep their previous contents.
- R5: In the data slot of a write, `dq_oe` is low whatever the level of `oe_n`.
- R6: While `oe_n` is high, `dq_oe` is low.
- R7: A load command (`load_n` low) with any chip enable inactive (`en_a_n` high, `en_b` low or `en_c_n` high) is a no-operation. Its data slot leaves `dq_oe` low, and the array is not written even if `we_n` and the byte selects are low.
- R8: A read taken on the edge right after a write to the same address returns that write's bus data for the selected bytes, merged with the stored value of the other bytes.
- R9: With `load_n` high, the chip enables and `we_n` are ignored. The previous access type continues at the burst address, whose low two bits are (start + k) mod 4 for the k-th advance and whose upper bits equal the start address. The byte selects are sampled again on every burst edge.
- R10: Any mix of reads, writes and deselects issued on consecutive edges with no idle cycles returns correct data in every read slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline (not the array) |
| addr | input | ADDR_W | Word address of a load command |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Low selects write, high selects read on a load command |
| load_n | input | 1 | Low loads a new command, high advances a burst |
| byte_we_n | input | BYTES | Per-byte write selects, active low |
| oe_n | input | 1 | Output enable, active low, gates the drivers only |
| dq_in | input | BYTES*8 | Bus value seen by the array (write data) |
| dq_out | output | BYTES*8 | Read data launched onto the bus |
| dq_oe | output | 1 | High while the block drives the bus |

## Verification
The bench first fills the array and then runs directed patterns. It issues plain reads, and partial byte writes followed by a read-back that separates a selected byte from one that is held. A write is followed at once by a read of the same address, which tells forwarding apart from a stale array read. A deselect carrying write controls shows that the array is left unchanged. A burst that starts mid-group shows the wrap of the low address bits, and a burst edge carrying bogus enables shows that they are ignored. After that, a seeded random mix of loads, bursts, deselects and output-enable toggles is issued on consecutive edges over a small address range. This makes write-then-read collisions and bus turnarounds frequent. The bench compares every data slot against a reference pipeline it keeps itself.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2
  } op_e;

  localparam int BURST_BITS = 2;
endpackage

// File: rtl/lw_sram_cmd.sv
module lw_sram_cmd
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic              sel,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTES-1:0]  byte_we_n,
  output op_e               op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [BYTES-1:0]  be_q
);
  localparam int BB = BURST_BITS;

  logic [ADDR_W-1:0] base_q;
  logic [BB-1:0]     step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_NOP;
      base_q <= '0;
      step_q <= '0;
      be_q   <= '0;
    end else begin
      be_q <= ~byte_we_n;
      if (!load_n) begin
        base_q <= addr;
        step_q <= '0;
        if (!sel)      op_q <= OP_NOP;
        else if (we_n) op_q <= OP_RD;
        else           op_q <= OP_WR;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end

  always_comb begin
    addr_q         = base_q;
    addr_q[BB-1:0] = base_q[BB-1:0] + step_q;
  end

  assert_desel_nop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && !sel) |=> (op_q == OP_NOP));

  assert_burst_keeps_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_n |=> (op_q == $past(op_q)));

  assert_burst_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_n |=> (addr_q[BB-1:0] == $past(addr_q[BB-1:0]) + 1'b1) &&
               (addr_q[ADDR_W-1:BB] == $past(addr_q[ADDR_W-1:BB])));
endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [BYTES-1:0]    wr_be,
  input  logic [BYTES*8-1:0]  wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [BYTES*8-1:0]  rd_word
);
  localparam int DW    = BYTES * 8;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem_q [DEPTH];
  logic          hit;

  assign hit = wr_en && (wr_addr == rd_addr);

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (wr_en && wr_be[i]) mem_q[wr_addr][i*8 +: 8] <= wr_data[i*8 +: 8];
    end

    always_comb begin
      if (hit && wr_be[i]) rd_word[i*8 +: 8] = wr_data[i*8 +: 8];
      else                 rd_word[i*8 +: 8] = mem_q[rd_addr][i*8 +: 8];
    end

    assert_byte_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_be[i]) |=>
        (mem_q[$past(wr_addr)][i*8 +: 8] == $past(mem_q[wr_addr][i*8 +: 8])));
  end
endmodule

// File: rtl/lw_sram_slot.sv
module lw_sram_slot
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  op_e                 cmd_op,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic [BYTES-1:0]    cmd_be,
  input  logic [BYTES*8-1:0]  rd_word,
  input  logic                oe_n,
  output logic                wr_en,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [BYTES-1:0]    wr_be,
  output logic [BYTES*8-1:0]  dq_out,
  output logic                dq_oe
);
  op_e slot_op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_op <= OP_NOP;
      wr_addr <= '0;
      wr_be   <= '0;
    end else begin
      slot_op <= cmd_op;
      wr_addr <= cmd_addr;
      wr_be   <= cmd_be;
    end
  end

  always_ff @(posedge clk) begin
    if (cmd_op == OP_RD) dq_out <= rd_word;
  end

  assign wr_en = (slot_op == OP_WR);
  assign dq_oe = (slot_op == OP_RD) && !oe_n;

  assert_wr_slot_hiz_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !dq_oe);

  assert_oe_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);
endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                en_a_n,
  input  logic                en_b,
  input  logic                en_c_n,
  input  logic                we_n,
  input  logic                load_n,
  input  logic [BYTES-1:0]    byte_we_n,
  input  logic                oe_n,
  input  logic [BYTES*8-1:0]  dq_in,
  output logic [BYTES*8-1:0]  dq_out,
  output logic                dq_oe
);
  localparam int DW = BYTES * 8;

  logic              sel;
  op_e               cmd_op;
  logic [ADDR_W-1:0] cmd_addr;
  logic [BYTES-1:0]  cmd_be;
  logic [DW-1:0]     rd_word;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [BYTES-1:0]  wr_be;

  assign sel = !en_a_n && en_b && !en_c_n;

  lw_sram_cmd #(.ADDR_W(ADDR_W), .BYTES(BYTES)) cmd_i (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .sel(sel), .we_n(we_n),
    .addr(addr), .byte_we_n(byte_we_n),
    .op_q(cmd_op), .addr_q(cmd_addr), .be_q(cmd_be)
  );

  lw_sram_array #(.ADDR_W(ADDR_W), .BYTES(BYTES)) array_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
    .wr_data(dq_in), .rd_addr(cmd_addr), .rd_word(rd_word)
  );

  lw_sram_slot #(.ADDR_W(ADDR_W), .BYTES(BYTES)) slot_i (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_be(cmd_be), .rd_word(rd_word), .oe_n(oe_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == OP_RD && !oe_n && $past(load_n)) |=> (dq_oe || oe_n));
endmodule

// File: tb/lw_sram_tb.sv
module lw_sram_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int DW = NB * 8;
  localparam int WATCHDOG_CYCLES = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          en_a_n = 1'b1, en_b = 1'b0, en_c_n = 1'b1;
  logic          we_n = 1'b1, load_n = 1'b0, oe_n = 1'b0;
  logic [NB-1:0] byte_we_n = '1;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  int checks = 0;
  int errors = 0;
  bit reported = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lw_sram #(.ADDR_W(AW), .BYTES(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .en_a_n(en_a_n), .en_b(en_b),
    .en_c_n(en_c_n), .we_n(we_n), .load_n(load_n), .byte_we_n(byte_we_n),
    .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // reference pipeline: op codes 0 nop, 1 read, 2 write
  logic [DW-1:0] ref_mem [1<<AW];
  int            m1_op = 0;
  logic [AW-1:0] m1_base = '0;
  logic [1:0]    m1_step = '0;
  logic [NB-1:0] m1_be = '0;
  string         m1_tag = "";
  int            md_op = 0;
  logic [AW-1:0] md_addr = '0;
  logic [NB-1:0] md_be = '0;
  logic [DW-1:0] md_data = '0;
  string         md_tag = "";

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old_w, logic [DW-1:0] new_w,
                                          logic [NB-1:0] be);
    logic [DW-1:0] r = old_w;
    for (int i = 0; i < NB; i++) if (be[i]) r[i*8 +: 8] = new_w[i*8 +: 8];
    return r;
  endfunction

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic check_slot();
    bit    exp_oe = (md_op == 1) && !oe_n;
    string t = (md_op == 2) ? "R5" : (oe_n ? "R6" : ((md_op == 0) ? "R7" : md_tag));
    checks++;
    if (dq_oe !== exp_oe) begin
      errors++;
      $display("FAIL %s: dq_oe actual %0b expected %0b", t, dq_oe, exp_oe);
    end
    if (exp_oe) begin
      checks++;
      if (dq_out !== md_data) begin
        errors++;
        $display("FAIL %s: dq_out actual %h expected %h", md_tag, dq_out, md_data);
      end
    end
  endtask

  // one command edge: ld=load, sel=all enables active, wr=write, bsel active-high bytes
  task automatic step(bit ld, bit sel, bit wr, logic [AW-1:0] a, logic [NB-1:0] bsel,
                      bit oe_hi, string tag);
    logic [AW-1:0] a1;
    logic [DW-1:0] nw, rd;
    @(negedge clk);
    check_slot();
    load_n    = !ld;
    addr      = a;
    we_n      = !wr;
    byte_we_n = ~bsel;
    oe_n      = oe_hi;
    if (sel) begin
      en_a_n = 1'b0; en_b = 1'b1; en_c_n = 1'b0;
    end else begin
      int k = $urandom % 3;
      en_a_n = (k == 0); en_b = (k != 1); en_c_n = (k == 2);
    end
    dq_in = {$urandom};
    @(posedge clk);
    a1 = m1_base;
    a1[1:0] = m1_base[1:0] + m1_step;
    nw = '0;
    if (md_op == 2) nw = merge(ref_mem[md_addr], dq_in, md_be);
    rd = ref_mem[a1];
    if (md_op == 2 && md_addr == a1) rd = nw;
    if (md_op == 2) ref_mem[md_addr] = nw;
    md_op = m1_op; md_addr = a1; md_be = m1_be; md_data = rd; md_tag = m1_tag;
    m1_be = bsel; m1_tag = tag;
    if (ld) begin
      m1_op = !sel ? 0 : (wr ? 2 : 1);
      m1_base = a; m1_step = '0;
    end else begin
      m1_step = m1_step + 2'd1;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, '0, '0, 0, "R7");
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;
    repeat (3) @(posedge clk);
    checks++;
    if (dq_oe !== 1'b0) begin
      errors++; $display("FAIL R1: dq_oe actual %0b expected 0 in reset", dq_oe);
    end
    @(negedge clk);
    rst_n = 1'b1;
    checks++;
    if (dq_oe !== 1'b0) begin
      errors++; $display("FAIL R1: dq_oe actual %0b expected 0 after reset", dq_oe);
    end
    // fill with back-to-back full writes (R3)
    for (int i = 0; i < 16; i++) step(1, 1, 1, AW'(i), '1, 0, "R3");
    idle(2);
    for (int i = 0; i < 4; i++) step(1, 1, 0, AW'(i), '0, 0, "R3");
    for (int i = 12; i < 16; i++) step(1, 1, 0, AW'(i), '0, 0, "R2");
    idle(2);
    // partial byte write, later read-back (R4)
    step(1, 1, 1, 6'd5, 4'b0101, 0, "R4");
    idle(2);
    step(1, 1, 0, 6'd5, '0, 0, "R4");
    idle(2);
    // write then immediate read of same address (R8)
    step(1, 1, 1, 6'd7, 4'b1001, 0, "R8");
    step(1, 1, 0, 6'd7, '0, 0, "R8");
    idle(2);
    // read whose slot sees oe_n high (R6)
    step(1, 1, 0, 6'd3, '0, 0, "R6");
    step(1, 0, 0, '0, '0, 1, "R6");
    step(1, 0, 0, '0, '0, 1, "R6");
    idle(2);
    // deselect carrying write controls, then read back (R7)
    step(1, 0, 1, 6'd9, '1, 0, "R7");
    idle(2);
    step(1, 1, 0, 6'd9, '0, 0, "R7");
    idle(2);
    // burst write from 10 (wraps 10,11,8,9) with bogus enables on advance (R9)
    step(1, 1, 1, 6'd10, '1, 0, "R9");
    step(0, 0, 0, 6'd33, 4'b0011, 0, "R9");
    step(0, 1, 0, 6'd34, '1, 0, "R9");
    step(0, 0, 1, 6'd35, 4'b1100, 0, "R9");
    step(1, 1, 0, 6'd10, '0, 0, "R9");
    step(0, 0, 1, 6'd40, '1, 0, "R9");
    step(0, 1, 1, 6'd41, '1, 0, "R9");
    step(0, 0, 1, 6'd42, '1, 0, "R9");
    // alternating read/write/read with no idle edges (R10)
    step(1, 1, 0, 6'd2, '0, 0, "R10");
    step(1, 1, 1, 6'd2, 4'b0110, 0, "R10");
    step(1, 1, 0, 6'd2, '0, 0, "R10");
    step(1, 1, 1, 6'd4, '1, 0, "R10");
    step(1, 1, 0, 6'd2, '0, 0, "R10");
    step(1, 1, 0, 6'd4, '0, 0, "R10");
    // random mix (R10)
    for (int i = 0; i < 600; i++) begin
      bit ld  = ($urandom % 5) != 0;
      bit sel = ($urandom % 8) != 0;
      bit wr  = $urandom % 2;
      bit oh  = ($urandom % 7) == 0;
      step(ld, sel, wr, AW'($urandom % 16), NB'($urandom), oh, "R10");
    end
    idle(3);
    report();
  end
endmodule